// File: doc/BRIEF.md
# Time-Multiplexed Operand-Buffer Processing Element

This block is one processing element of a statically scheduled, coarse-grained compute overlay. Operand words arrive from one or more network channels. Each operand register can capture the word of a chosen channel into its own short shift register. In each cycle the element picks one stored word from each shift register by its age and sends the pair into a pipelined arithmetic unit. The capture, channel, pick and issue decisions for a cycle come from a small context memory. A phase counter steps through that memory modulo II, so the element repeats the same II-cycle pattern for as long as it runs.

A static setting makes the element an adder, a multiplier or an I/O port. In I/O mode the external input word goes down the result path, and the operand picked from register A is driven out on the external output. The schedule is fixed when the design is compiled, so there is no back-pressure. Every data pin is a plain word with a valid qualifier where one is needed, and a consumer must accept a word in the cycle it appears. The compiler loads the context memory while the configuration enable is high. While that enable is high the element stays quiet.

Top module: `tmpe_core`

## Requirements
- R1: With kind code 0 (add), an issued operation gives (A + B) mod 2^W.
- R2: With kind code 1 (multiply), an issued operation gives the low W bits of A * B.
- R3: Each operand register is a D-deep shift register. When its capture bit is set, the chosen channel word enters at age 0 and older words move one age up. A select value s picks the word at age s, where age 0 is the most recent capture. When the capture bit is clear, the contents stay unchanged.
- R4: The phase counter counts 0, 1, ..., II-1 and then wraps to 0. Context entry p controls every cycle in which the phase is p.
- R5: A context entry is written only in cycles where cfg_en is high, using cfg_addr and cfg_data. While cfg_en is high the phase is forced to 0, no capture takes place and nothing is issued.
- R6: The channel field of each register picks which channel word that register captures. Channel c occupies ch_in[c*W +: W].
- R7: res_valid is high exactly L cycles after a cycle in which the context issue bit was set and cfg_en was low. In that cycle res_data carries the result of that issue.
- R8: With kind code 2 (I/O), an issued operation sends the io_in_data sampled in the issue cycle to res_data after L cycles. Operand A appears on io_out_data with io_out_valid high in the next cycle. In other kinds io_out_valid stays low.
- R9: The context word, from the least significant bit up, is: issue at bit 0, capture A at bit 1, capture B at bit 2, channel A, channel B (each max(1, ceil(log2 NCH)) bits), select A, select B (each max(1, ceil(log2 D)) bits).
- R10: While rst_n is low, res_valid, io_out_valid, res_data and io_out_data are 0, the shift registers are cleared and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_kind | input | 2 | Element kind: 0 add, 1 multiply, 2 I/O |
| cfg_en | input | 1 | Configuration enable and context write strobe |
| cfg_addr | input | max(1, ceil(log2 II)) | Context entry to write |
| cfg_data | input | 3+2*CHW+2*SW | Context word to write |
| ch_in | input | NCH*W | Words arriving from the channels, channel c at bits c*W upward |
| io_in_data | input | W | External word driven onto the result path in I/O mode |
| res_data | output | W | Result toward the local router |
| res_valid | output | 1 | res_data carries a new result |
| io_out_data | output | W | Operand A sent out in I/O mode |
| io_out_valid | output | 1 | io_out_data carries a new word |

## Verification
The bench builds the element with W=8, D=4, II=4, NCH=2 and L=3. At an 8-bit width, every value of A can be paired with a spread of B values for both add and multiply, so all carry-out and product-overflow cases fall inside one short run. Four phases and four ages, with two channels, are small enough that random context words reach every select value, channel choice, capture pattern and phase wrap many times. Configuration pauses in the middle of a run and kind changes between runs show that results already in flight drain with the kind they were issued under.

// File: rtl/tmpe_pkg.sv
package tmpe_pkg;
  typedef enum logic [1:0] {
    PE_ADD = 2'd0,
    PE_MUL = 2'd1,
    PE_IO  = 2'd2
  } pe_kind_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tmpe_ctx_seq.sv
module tmpe_ctx_seq #(
  parameter int II   = 4,
  parameter int CTXW = 9,
  parameter int PW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_en,
  input  logic [PW-1:0]   cfg_addr,
  input  logic [CTXW-1:0] cfg_data,
  output logic [PW-1:0]   phase,
  output logic [CTXW-1:0] ctx_word
);
  localparam logic [PW-1:0] LAST = PW'(II - 1);

  logic [CTXW-1:0] ctx_mem [II];

  always_ff @(posedge clk) begin
    if (cfg_en && (int'(cfg_addr) < II))
      ctx_mem[cfg_addr] <= cfg_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               phase <= '0;
    else if (cfg_en)          phase <= '0;
    else if (phase == LAST)   phase <= '0;
    else                      phase <= phase + 1'b1;
  end

  assign ctx_word = ctx_mem[phase];
endmodule

// File: rtl/tmpe_opbuf.sv
module tmpe_opbuf #(
  parameter int W   = 32,
  parameter int D   = 4,
  parameter int NCH = 2,
  parameter int CHW = 1,
  parameter int SW  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic [CHW-1:0]   chan,
  input  logic [SW-1:0]    sel,
  input  logic [NCH*W-1:0] ch_in,
  output logic [W-1:0]     operand,
  output logic [D*W-1:0]   store
);
  logic [W-1:0] slot [D];
  logic [W-1:0] arriving;

  always_comb begin
    arriving = '0;
    for (int c = 0; c < NCH; c++)
      if (int'(chan) == c) arriving = ch_in[c*W +: W];
  end

  for (genvar i = 0; i < D; i++) begin : g_slot
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot[0] <= '0;
        else if (cap) slot[0] <= arriving;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot[i] <= '0;
        else if (cap) slot[i] <= slot[i-1];
      end
    end
    assign store[i*W +: W] = slot[i];
  end

  always_comb begin
    operand = '0;
    for (int i = 0; i < D; i++)
      if (int'(sel) == i) operand = slot[i];
  end
endmodule

// File: rtl/tmpe_alu.sv
module tmpe_alu
  import tmpe_pkg::*;
#(
  parameter int W = 32,
  parameter int L = 3
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     issue,
  input  pe_kind_e kind,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [W-1:0] io_in,
  output logic [W-1:0] res,
  output logic     res_v
);
  localparam int NPIPE = L - 1;

  logic         s1_v;
  pe_kind_e     s1_kind;
  logic [W-1:0] s1_a, s1_b, s1_io;
  logic [W-1:0] comp;
  logic [2*W-1:0] prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_kind <= PE_ADD;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_io   <= '0;
    end else begin
      s1_v <= issue;
      if (issue) begin
        s1_kind <= kind;
        s1_a    <= opa;
        s1_b    <= opb;
        s1_io   <= io_in;
      end
    end
  end

  assign prod = {{W{1'b0}}, s1_a} * {{W{1'b0}}, s1_b};

  always_comb begin
    case (s1_kind)
      PE_MUL:  comp = prod[W-1:0];
      PE_IO:   comp = s1_io;
      default: comp = s1_a + s1_b;
    endcase
  end

  logic         pv [NPIPE];
  logic [W-1:0] pd [NPIPE];

  for (genvar k = 0; k < NPIPE; k++) begin : g_stage
    if (k == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pv[0] <= 1'b0;
          pd[0] <= '0;
        end else begin
          pv[0] <= s1_v;
          if (s1_v) pd[0] <= comp;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pv[k] <= 1'b0;
          pd[k] <= '0;
        end else begin
          pv[k] <= pv[k-1];
          if (pv[k-1]) pd[k] <= pd[k-1];
        end
      end
    end
  end

  assign res   = pd[NPIPE-1];
  assign res_v = pv[NPIPE-1];
endmodule

// File: rtl/tmpe_core.sv
module tmpe_core
  import tmpe_pkg::*;
#(
  parameter int W   = 32,
  parameter int D   = 4,
  parameter int II  = 4,
  parameter int NCH = 2,
  parameter int L   = 3,
  localparam int CHW  = idx_bits(NCH),
  localparam int SW   = idx_bits(D),
  localparam int PW   = idx_bits(II),
  localparam int CTXW = 3 + 2*CHW + 2*SW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_kind,
  input  logic             cfg_en,
  input  logic [PW-1:0]    cfg_addr,
  input  logic [CTXW-1:0]  cfg_data,
  input  logic [NCH*W-1:0] ch_in,
  input  logic [W-1:0]     io_in_data,
  output logic [W-1:0]     res_data,
  output logic             res_valid,
  output logic [W-1:0]     io_out_data,
  output logic             io_out_valid
);
  localparam int OFS_ISS  = 0;
  localparam int OFS_CAPA = 1;
  localparam int OFS_CAPB = 2;
  localparam int OFS_CHA  = 3;
  localparam int OFS_CHB  = OFS_CHA + CHW;
  localparam int OFS_SELA = OFS_CHB + CHW;
  localparam int OFS_SELB = OFS_SELA + SW;

  logic [PW-1:0]   phase;
  logic [CTXW-1:0] ctx;
  logic            running, issue, cap_a, cap_b;
  pe_kind_e        kind;

  logic           cap_v  [2];
  logic [CHW-1:0] chan_v [2];
  logic [SW-1:0]  sel_v  [2];
  logic [W-1:0]   opnd   [2];
  logic [D*W-1:0] stv    [2];
  logic [D*W-1:0] buf_a, buf_b;

  assign kind    = pe_kind_e'(cfg_kind);
  assign running = !cfg_en;
  assign issue   = running && ctx[OFS_ISS];
  assign cap_a   = running && ctx[OFS_CAPA];
  assign cap_b   = running && ctx[OFS_CAPB];

  assign cap_v[0]  = cap_a;
  assign cap_v[1]  = cap_b;
  assign chan_v[0] = ctx[OFS_CHA +: CHW];
  assign chan_v[1] = ctx[OFS_CHB +: CHW];
  assign sel_v[0]  = ctx[OFS_SELA +: SW];
  assign sel_v[1]  = ctx[OFS_SELB +: SW];

  tmpe_ctx_seq #(.II(II), .CTXW(CTXW), .PW(PW)) u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_en   (cfg_en),
    .cfg_addr (cfg_addr),
    .cfg_data (cfg_data),
    .phase    (phase),
    .ctx_word (ctx)
  );

  for (genvar g = 0; g < 2; g++) begin : g_buf
    tmpe_opbuf #(.W(W), .D(D), .NCH(NCH), .CHW(CHW), .SW(SW)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .cap     (cap_v[g]),
      .chan    (chan_v[g]),
      .sel     (sel_v[g]),
      .ch_in   (ch_in),
      .operand (opnd[g]),
      .store   (stv[g])
    );
  end

  assign buf_a = stv[0];
  assign buf_b = stv[1];

  tmpe_alu #(.W(W), .L(L)) u_alu (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .kind  (kind),
    .opa   (opnd[0]),
    .opb   (opnd[1]),
    .io_in (io_in_data),
    .res   (res_data),
    .res_v (res_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_out_valid <= 1'b0;
      io_out_data  <= '0;
    end else begin
      io_out_valid <= issue && (kind == PE_IO);
      if (issue && (kind == PE_IO)) io_out_data <= opnd[0];
    end
  end
endmodule

// File: rtl/tmpe_core_chk.sv
module tmpe_core_chk #(
  parameter int W  = 32,
  parameter int D  = 4,
  parameter int II = 4,
  parameter int PW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_en,
  input logic [1:0]     cfg_kind,
  input logic [PW-1:0]  phase,
  input logic           cap_a,
  input logic           cap_b,
  input logic [D*W-1:0] buf_a,
  input logic [D*W-1:0] buf_b,
  input logic           io_out_valid
);
  localparam logic [PW-1:0] LAST = PW'(II - 1);

  // R4: counter wraps after the last phase
  a_r4_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && phase == LAST) |=> (phase == '0));

  // R4: counter steps by one otherwise
  a_r4_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && phase != LAST) |=> (phase == PW'($past(phase) + 1'b1)));

  // R5: configuration holds phase at zero
  a_r5_cfg_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> (phase == '0));

  // R5: nothing issues while configuring
  a_r5_cfg_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> !io_out_valid);

  // R3: register A unchanged without capture
  a_r3_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_a |=> $stable(buf_a));

  // R3: register B unchanged without capture
  a_r3_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_b |=> $stable(buf_b));

  // R8: external output only in I/O kind
  a_r8_io_out_kind: assert property (@(posedge clk) disable iff (!rst_n)
    io_out_valid |-> ($past(cfg_kind) == 2'd2));
endmodule

bind tmpe_core tmpe_core_chk #(.W(W), .D(D), .II(II), .PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_en       (cfg_en),
  .cfg_kind     (cfg_kind),
  .phase        (phase),
  .cap_a        (cap_a),
  .cap_b        (cap_b),
  .buf_a        (buf_a),
  .buf_b        (buf_b),
  .io_out_valid (io_out_valid)
);

// File: tb/tmpe_core_bench.sv
`timescale 1ns/1ps
module tmpe_core_bench;
  localparam int W = 8, D = 4, II = 4, NCH = 2, L = 3;
  localparam int CTXW = 9;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       cfg_kind = 2'd0;
  logic             cfg_en = 1'b0;
  logic [1:0]       cfg_addr = '0;
  logic [CTXW-1:0]  cfg_data = '0;
  logic [NCH*W-1:0] ch_in = '0;
  logic [W-1:0]     io_in_data = '0;
  logic [W-1:0]     res_data, io_out_data;
  logic             res_valid, io_out_valid;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tmpe_core #(.W(W), .D(D), .II(II), .NCH(NCH), .L(L)) u_tmpe_core (
    .clk(clk), .rst_n(rst_n), .cfg_kind(cfg_kind), .cfg_en(cfg_en),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .ch_in(ch_in),
    .io_in_data(io_in_data), .res_data(res_data), .res_valid(res_valid),
    .io_out_data(io_out_data), .io_out_valid(io_out_valid)
  );

  // reference state
  logic [W-1:0]    ma [D];
  logic [W-1:0]    mb [D];
  logic [CTXW-1:0] mctx [II];
  int              mphase = 0;
  logic            ev [L];
  logic [W-1:0]    ed [L];
  int              ek [L];
  logic            eio_v = 0;
  logic [W-1:0]    eio_d = '0;

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // one clock: predict with current inputs, clock, compare at negedge
  task automatic cycle();
    logic [CTXW-1:0] c;
    logic iss, capa, capb;
    logic [W-1:0] oa, ob, r, wa, wb;
    logic [2*W-1:0] p;
    c = '0; iss = 0; capa = 0; capb = 0; r = '0; oa = '0; ob = '0;
    if (cfg_en) begin
      mctx[cfg_addr] = cfg_data;
    end else begin
      c = mctx[mphase];
      iss = c[0]; capa = c[1]; capb = c[2];
      oa = ma[c[6:5]]; ob = mb[c[8:7]];
      p = {{W{1'b0}}, oa} * {{W{1'b0}}, ob};
      case (cfg_kind)
        2'd1: r = p[W-1:0];
        2'd2: r = io_in_data;
        default: r = oa + ob;
      endcase
    end
    wa = ch_in[int'(c[3])*W +: W];
    wb = ch_in[int'(c[4])*W +: W];
    for (int k = L-1; k > 0; k--) begin
      ev[k] = ev[k-1];
      if (ev[k-1]) begin ed[k] = ed[k-1]; ek[k] = ek[k-1]; end
    end
    ev[0] = iss;
    if (iss) begin ed[0] = r; ek[0] = int'(cfg_kind); end
    eio_v = iss && (cfg_kind == 2'd2);
    if (eio_v) eio_d = oa;
    if (capa) begin
      for (int i = D-1; i > 0; i--) ma[i] = ma[i-1];
      ma[0] = wa;
    end
    if (capb) begin
      for (int i = D-1; i > 0; i--) mb[i] = mb[i-1];
      mb[0] = wb;
    end
    mphase = cfg_en ? 0 : ((mphase == II-1) ? 0 : mphase + 1);
    @(posedge clk);
    @(negedge clk);
    check(res_valid == ev[L-1], "R7/R5 res_valid timing", res_valid, ev[L-1]);
    if (ev[L-1]) begin
      case (ek[L-1])
        1: check(res_data == ed[L-1], "R2/R3/R4/R6/R9 multiply result", res_data, ed[L-1]);
        2: check(res_data == ed[L-1], "R8/R3/R4/R9 io result", res_data, ed[L-1]);
        default: check(res_data == ed[L-1], "R1/R3/R4/R6/R9 add result", res_data, ed[L-1]);
      endcase
    end
    check(io_out_valid == eio_v, "R8/R5 io_out_valid", io_out_valid, eio_v);
    if (eio_v) check(io_out_data == eio_d, "R8/R3 io_out_data", io_out_data, eio_d);
  endtask

  function automatic logic [W-1:0] pick_word();
    logic [W-1:0] edge_vals [5] = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF};
    if ($urandom_range(3) == 0) return edge_vals[$urandom_range(4)];
    return W'($urandom);
  endfunction

  task automatic load_ctx(input int kind, input bit random_ctx);
    cfg_kind = 2'(kind);
    cfg_en = 1'b1;
    for (int a = 0; a < II; a++) begin
      cfg_addr = 2'(a);
      if (random_ctx) begin
        cfg_data = CTXW'($urandom);
        if ($urandom_range(3) != 0) cfg_data[0] = 1'b1;
      end else begin
        cfg_data = 9'h017; // issue, capture A from ch0, B from ch1, ages 0
      end
      ch_in = {pick_word(), pick_word()};
      cycle();
    end
    cfg_en = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      ch_in = {pick_word(), pick_word()};
      io_in_data = pick_word();
      cfg_addr = 2'($urandom);
      cfg_data = CTXW'($urandom);
      cycle();
    end
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin ma[i] = '0; mb[i] = '0; end
    for (int k = 0; k < L; k++) begin ev[k] = 0; ed[k] = '0; ek[k] = 0; end
    repeat (3) @(negedge clk);
    // R10 reset state
    check(res_valid == 1'b0, "R10 res_valid in reset", res_valid, 0);
    check(io_out_valid == 1'b0, "R10 io_out_valid in reset", io_out_valid, 0);
    check(res_data == '0, "R10 res_data in reset", res_data, 0);
    check(io_out_data == '0, "R10 io_out_data in reset", io_out_data, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // exhaustive-style sweep: every A against 16 B values, add then multiply
    for (int kind = 0; kind < 2; kind++) begin
      load_ctx(kind, 1'b0);
      for (int a = 0; a < 256; a++) begin
        for (int bi = 0; bi < 16; bi++) begin
          ch_in = {8'(bi * 17), 8'(a)};
          cycle();
        end
      end
    end

    // random schedules for every kind, with configuration pauses mid-run
    for (int kind = 0; kind < 3; kind++) begin
      for (int rnd = 0; rnd < 8; rnd++) begin
        load_ctx(kind, 1'b1);
        run(40);
        cfg_en = 1'b1;
        cfg_addr = 2'($urandom);
        cfg_data = CTXW'($urandom) | 9'h001;
        cycle();
        cycle();
        cfg_en = 1'b0;
        run(24);
      end
    end

    // drain
    cfg_en = 1'b1;
    cycle(); cycle(); cycle(); cycle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R7 actual=%0d expected=%0d cycles", 150000, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule